// File: doc/BRIEF.md
# Dual-Read Register File with Null Identifier

This block holds the general-purpose registers of a small processor datapath: eight words of 32 bits, reached through two read ports and one write port. Every port is addressed by a 4-bit register identifier. The two read ports are purely combinational. Each data output follows its identifier within the same cycle, and no clock edge is involved. The write port stores its data on the rising clock edge, into the register that the destination identifier names.

Identifier 8 is reserved to mean "no register". Every identifier from 8 to 15 is handled the same way. A read port given such an identifier returns zero, and a write given one changes nothing. This lets a decoder pass an operand field straight through when an instruction names no operand, with no separate enable line. Reads are not bypassed. While a write to a register is pending, a read of that register returns the old contents until the clock edge. A synchronous active-low reset clears all eight registers.

Top module: `rf_dual_read`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, all eight registers become zero, and reset takes priority over a write in the same cycle.
- R2: A read port whose identifier is 0 to 7 outputs the current contents of that register combinationally, within the same cycle that the identifier changes.
- R3: A read port whose identifier is 8 (the null identifier) outputs 32'h0000_0000.
- R4: A read port whose identifier is 9 to 15 also outputs 32'h0000_0000.
- R5: At a rising edge with `rst_n` high and `wr_id` in 0 to 7, the register numbered `wr_id` takes `wr_data`, and no other register changes.
- R6: A write with `wr_id` equal to 8 leaves all registers unchanged.
- R7: A write with `wr_id` from 9 to 15 leaves all registers unchanged.
- R8: A read of the register being written in the same cycle returns the old value before the edge and the new value after it.
- R9: The two read ports work independently, may name the same register, and operate in the same cycle as the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_id | input | 4 | Identifier for read port A (8 to 15 means none) |
| rd_a_data | output | 32 | Read port A data |
| rd_b_id | input | 4 | Identifier for read port B (8 to 15 means none) |
| rd_b_data | output | 32 | Read port B data |
| wr_id | input | 4 | Destination identifier for the write (8 to 15 means none) |
| wr_data | input | 32 | Data to write |

## Verification
The overlap of interest is a write and a read that target the same register in one cycle. The bench drives `wr_id`, `rd_a_id` and `rd_b_id` to one register before an edge. It judges the ports just before that edge, where the old value must still be visible, and again just after it, where the new value must appear. The bench also sweeps every pair of read identifiers, 0 to 15 on both ports, after several write patterns and after writes with each null identifier. All expected values come from a model array in the bench.

// File: rtl/rf_pkg.sv
// Package: rf_pkg
// Shared defaults and register naming for the dual-read register file.
// Assumes identifiers at or above the register count name no register.
package rf_pkg;
    localparam int RF_DATA_W   = 32;
    localparam int RF_NUM_REGS = 8;
    localparam int RF_ID_W     = 4;

    typedef enum logic [RF_ID_W-1:0] {
        GP0 = 4'd0, GP1 = 4'd1, GP2 = 4'd2, GP3 = 4'd3,
        GP4 = 4'd4, GP5 = 4'd5, GP6 = 4'd6, GP7 = 4'd7,
        GP_NONE = 4'd8
    } rf_id_e;
endpackage

// File: rtl/rf_id_decode.sv
// Module: rf_id_decode
// Turns a register identifier into a one-hot select. Any identifier at or
// above NUM_REGS yields an all-zero select (no register).
// Assumes 2**ID_W >= NUM_REGS.
module rf_id_decode #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic [ID_W-1:0]     id,
    output logic [NUM_REGS-1:0] sel
);
    // Purpose: one bit per register, raised only when the identifier matches it.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            sel[i] = (id == ID_W'(i));
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// Holds NUM_REGS words. A one-hot select picks the register loaded on the
// rising edge; an all-zero select writes nothing. Synchronous active-low
// reset clears every word and wins over a write.
module rf_storage #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REGS-1:0]            wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Purpose: reset, load on select, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_sel[g])
                regs_q[g] <= wr_data;
        end

        // R1: the cycle after reset every word reads zero
        assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (regs_q[g] == '0));

        // R5: a selected word holds the data presented at the edge
        assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_sel[g])) |-> (regs_q[g] == $past(wr_data)));

        // R6 / R7: an unselected word never moves
        assert_unselected_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(wr_sel[g])) |-> $stable(regs_q[g]));
    end

    // R5: at most one word is ever loaded at once
    assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/rf_read_port.sv
// Module: rf_read_port
// One combinational read port. Identifiers at or above NUM_REGS return zero.
// Assumes 2**ID_W >= NUM_REGS and NUM_REGS is a power of two.
module rf_read_port #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic [ID_W-1:0]                 id,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
    output logic [DATA_W-1:0]               data
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              id_valid;
    logic [SEL_W-1:0]  idx;

    // Purpose: split the identifier into a range check and a word index.
    always_comb begin
        id_valid = (id < ID_W'(NUM_REGS));
        idx      = id[SEL_W-1:0];
    end

    // Purpose: select the word, forcing zero for a null identifier.
    always_comb begin
        data = id_valid ? regs_q[idx] : '0;
    end
endmodule

// File: rtl/rf_dual_read.sv
// Module: rf_dual_read
// Register file top: two combinational read ports, one clocked write port,
// 4-bit identifiers with 8..15 meaning "no register". Reads are not bypassed.
module rf_dual_read #(
    parameter int NUM_REGS = rf_pkg::RF_NUM_REGS,
    parameter int DATA_W   = rf_pkg::RF_DATA_W,
    parameter int ID_W     = rf_pkg::RF_ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [NUM_RD-1:0][ID_W-1:0]     rd_id;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_q;

    // Purpose: gather the read identifiers so the ports can be generated.
    always_comb begin
        rd_id[0] = rd_a_id;
        rd_id[1] = rd_b_id;
    end

    // Purpose: drive the outputs from the generated read ports.
    always_comb begin
        rd_a_data = rd_q[0];
        rd_b_data = rd_q[1];
    end

    rf_id_decode #(.NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_wr_decode (
        .id  (wr_id),
        .sel (wr_sel)
    );

    rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W)) u_port (
            .id     (rd_id[p]),
            .regs_q (regs_q),
            .data   (rd_q[p])
        );

        // R3 / R4: a null identifier on a read port yields zero
        assert_null_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_id[p] >= ID_W'(NUM_REGS)) |-> (rd_q[p] == '0));

        // R2 / R8: with a steady identifier, read data moves only after a write to it
        assert_read_moves_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $stable(rd_id[p]) && ($past(wr_id) != rd_id[p]))
            |-> $stable(rd_q[p]));
    end

    // R7: the write decoder selects nothing for identifiers 8..15
    assert_null_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_id >= ID_W'(NUM_REGS)) |-> (wr_sel == '0));
endmodule

// File: tb/test_rf_dual_read.sv
// Bench: test_rf_dual_read
// Sweeps every read identifier pair after several write patterns and checks
// against a model array kept in the bench.
module test_rf_dual_read;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_id = 4'd8;
    logic [3:0]  rd_b_id = 4'd8;
    logic [3:0]  wr_id = 4'd8;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a_data, rd_b_data;

    logic [31:0] model [8];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rf_dual_read i_rf_dual_read (
        .clk(clk), .rst_n(rst_n),
        .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_id(wr_id), .wr_data(wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_rd(input int id);
        return (id < 8) ? model[id] : 32'h0;
    endfunction

    // all 256 identifier pairs on both ports; 0..7 R2, 8 R3, 9..15 R4, both R9
    task automatic sweep(input string tag);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                @(negedge clk);
                rd_a_id = 4'(a);
                rd_b_id = 4'(b);
                #1;
                chk({tag, (a < 8) ? " R2 portA" : (a == 8) ? " R3 portA" : " R4 portA"},
                    rd_a_data, expect_rd(a));
                chk({tag, (b < 8) ? " R2 portB R9" : (b == 8) ? " R3 portB" : " R4 portB"},
                    rd_b_data, expect_rd(b));
            end
        end
    endtask

    task automatic write_reg(input int id, input logic [31:0] d);
        @(negedge clk);
        wr_id = 4'(id);
        wr_data = d;
        @(posedge clk);
        if (id < 8) model[id] = d;
        @(negedge clk);
        wr_id = 4'd8;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        // reset with a write pending: reset wins (R1)
        wr_id = 4'd2; wr_data = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr_id = 4'd8;
        rst_n = 1'b1;
        sweep("reset R1");

        // pattern 1: distinct arithmetic values (R5)
        for (int i = 0; i < 8; i++) write_reg(i, 32'hC0DE_0000 + 32'(i) * 32'h0101_0111);
        sweep("pattern1 R5");

        // null writes with 8..15 (R6, R7)
        for (int i = 8; i < 16; i++) write_reg(i, 32'h5A5A_0000 | 32'(i));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rd_a_id = 4'(i); #1;
            chk((i % 2 == 0) ? "null write R6" : "null write R7", rd_a_data, model[i]);
        end
        sweep("after null R7");

        // pattern 2: walking one, single register at a time, others untouched (R5)
        for (int i = 0; i < 8; i++) begin
            write_reg(i, 32'h1 << (i * 4));
            for (int j = 0; j < 8; j++) begin
                @(negedge clk); rd_b_id = 4'(j); #1;
                chk("walk R5", rd_b_data, model[j]);
            end
        end

        // combinational read: identifier changes mid-cycle (R2)
        @(negedge clk);
        rd_a_id = 4'd5; #0.5;
        chk("comb R2", rd_a_data, model[5]);
        rd_a_id = 4'd6; #0.5;
        chk("comb R2", rd_a_data, model[6]);

        // no bypass: read and write same register in one cycle (R8, R9)
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            rd_a_id = 4'(r); rd_b_id = 4'(r);
            wr_id = 4'(r); wr_data = ~model[r];
            #1;
            chk("before edge R8", rd_a_data, model[r]);
            chk("before edge R9", rd_b_data, model[r]);
            @(posedge clk);
            model[r] = wr_data;
            #1;
            chk("after edge R8", rd_a_data, model[r]);
            chk("after edge R9", rd_b_data, model[r]);
            @(negedge clk); wr_id = 4'd8;
        end

        // extremes then reset again (R1)
        write_reg(0, 32'hFFFF_FFFF);
        write_reg(7, 32'h8000_0000);
        sweep("extremes R2");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 8; i++) model[i] = '0;
        @(negedge clk); rst_n = 1'b1;
        sweep("rereset R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule